// File: doc/BRIEF.md
# UART Receive DMA Request Controller

This block drives the request side of the handshake between a UART receive FIFO and a system DMA engine. It watches the FIFO fill level and raises a burst request or a single-entry request. Each request is held until the engine acknowledges it. The acknowledge then turns into a pop strobe, with an entry count, back to the FIFO.

The block has two flow-control modes, chosen by `cfg_uart_fc`.

- **Engine flow control** (`cfg_uart_fc`=0): the DMA engine owns the block length. The controller issues bursts and singles whenever data is present and never marks a transfer as last.
- **UART flow control** (`cfg_uart_fc`=1): the controller decides where a packet ends. An idle timer restarts on every received character. When the line has been quiet for the programmed number of cycles, the controller enters a flush. During the flush it drains whole bursts first and then single entries, and it flags the single that moves the final entry as last. If the flush finds the FIFO already empty, the packet ended exactly on a burst boundary. In that case the controller issues one empty single transfer marked last and sets a sticky flag for software.

Top module: `uart_rx_dma_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `dma_burst_req`, `dma_single_req`, `dma_last`, `fifo_pop` and `dummy_flag` are 0.
- R2: When no request is outstanding and `fifo_level` >= `cfg_burst_len` (with `cfg_burst_len` nonzero), `dma_burst_req` goes high at the next clock edge. Burst takes priority over single.
- R3: In engine flow-control mode (`cfg_uart_fc`=0), when no request is outstanding and 0 < `fifo_level` < `cfg_burst_len`, `dma_single_req` goes high at the next clock edge.
- R4: A request stays high until `dma_ack` is sampled, and only one request is high at a time. At the edge that samples the acknowledge, the request drops and `fifo_pop` pulses for one cycle. `fifo_pop_cnt` equals `cfg_burst_len` for a burst and 1 for a single.
- R5: After each acknowledge the controller waits one settle cycle, so the next request is judged on the updated level. It can first appear two edges after the acknowledge edge.
- R6: In engine flow-control mode `dma_last` is never asserted and no idle timeout acts, however long the line stays quiet.
- R7: In UART flow-control mode, each `rx_char_stb` restarts the idle count. If `cfg_idle_thres` (at least 1) cycles then pass without a strobe, the flush begins. Its first request can rise at the edge `cfg_idle_thres`+3 edges after the edge that sampled the last strobe.
- R8: In UART flow-control mode, singles are issued only during a flush. A flush drains bursts first and then singles. `dma_last` is high together with the single issued when `fifo_level` is 1.
- R9: If a flush finds `fifo_level` at 0, the controller raises `dma_single_req` and `dma_last` together and sets `dummy_flag` at the same edge. The acknowledge of this dummy transfer leaves `fifo_pop` low.
- R10: `dummy_flag` stays set until a cycle with `dummy_clr`=1 clears it. Setting takes precedence over clearing.
- R11: An acknowledged last transfer ends the flush. With the FIFO empty, no further request appears until new data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_uart_fc | input | 1 | 1: UART ends blocks by idle timeout; 0: DMA engine ends blocks |
| cfg_burst_len | input | LVL_W | Entries moved per burst transfer |
| cfg_idle_thres | input | TMO_W | Quiet cycles that end a packet |
| fifo_level | input | LVL_W | Current receive FIFO fill level |
| rx_char_stb | input | 1 | One-cycle pulse per received character |
| dma_ack | input | 1 | DMA engine acknowledge of the pending request |
| dummy_clr | input | 1 | Write-one-to-clear for the dummy flag |
| dma_burst_req | output | 1 | Burst request |
| dma_single_req | output | 1 | Single request |
| dma_last | output | 1 | Marks the pending single as the last of the block |
| fifo_pop | output | 1 | One-cycle pop strobe to the FIFO |
| fifo_pop_cnt | output | LVL_W | Entries to pop with `fifo_pop` |
| dummy_flag | output | 1 | Sticky: an empty last transfer was issued |

## Verification
Every output is registered, so each result is due a fixed number of edges after its cause:

- A request appears one edge after the level is visible.
- A pop strobe appears at the edge that samples the acknowledge.
- The next request cannot appear until two edges after that acknowledge edge.
- A flush request appears `cfg_idle_thres`+3 edges after the last character strobe.

The bench drives inputs and samples outputs 1 ns after each rising edge. It counts edges from each stimulus and checks each output at the exact edge where it is due, and also at the edge just before, where it must still be absent. A bench-side FIFO model applies pushes and pop counts, so the levels the controller sees follow from the requirements alone.

// File: rtl/uart_rx_dma_pkg.sv
package uart_rx_dma_pkg;

  // Handshake sequencer states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BURST  = 2'd1,
    ST_SINGLE = 2'd2,
    ST_SETTLE = 2'd3
  } rxdma_state_e;

endpackage

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             char_stb,
  input  logic             clear,
  input  logic [TMO_W-1:0] thres,
  output logic             expire_o
);

  localparam logic [TMO_W-1:0] STEP = TMO_W'(1);

  logic             armed;
  logic [TMO_W-1:0] cnt;

  // Armed by a character, restarted by each further one, disarmed on expiry
  // or when a block completes.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      armed    <= 1'b0;
      cnt      <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (char_stb) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (clear) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (armed) begin
        if (cnt == thres) begin
          expire_o <= 1'b1;
          armed    <= 1'b0;
        end else begin
          cnt <= cnt + STEP;
        end
      end
    end
  end

  // R7: an expiry never directly follows a character strobe
  assert_expire_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> !$past(char_stb));

  // R7: expiry is a single-cycle event per quiet period
  assert_expire_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);

endmodule

// File: rtl/rx_dma_fsm.sv
module rx_dma_fsm
  import uart_rx_dma_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             uart_fc,
  input  logic [LVL_W-1:0] burst_len,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             dma_ack,
  input  logic             tmo,
  input  logic             dummy_clr,
  output logic             burst_req,
  output logic             single_req,
  output logic             last,
  output logic             pop,
  output logic [LVL_W-1:0] pop_cnt,
  output logic             dummy_flag,
  output logic             blk_done
);

  localparam logic [LVL_W-1:0] ONE_ENTRY = LVL_W'(1);

  rxdma_state_e state;
  logic         flush;
  logic         is_dummy;
  logic         has_burst;
  logic         has_data;

  assign has_burst = (burst_len != '0) && (fifo_level >= burst_len);
  assign has_data  = (fifo_level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      burst_req  <= 1'b0;
      single_req <= 1'b0;
      last       <= 1'b0;
      pop        <= 1'b0;
      pop_cnt    <= '0;
      dummy_flag <= 1'b0;
      blk_done   <= 1'b0;
      flush      <= 1'b0;
      is_dummy   <= 1'b0;
    end else begin
      pop      <= 1'b0;
      blk_done <= 1'b0;
      if (!uart_fc)  flush <= 1'b0;
      else if (tmo)  flush <= 1'b1;
      if (dummy_clr) dummy_flag <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (has_burst) begin
            burst_req <= 1'b1;
            state     <= ST_BURST;
          end else if (has_data && (!uart_fc || flush)) begin
            single_req <= 1'b1;
            last       <= flush && (fifo_level == ONE_ENTRY);
            is_dummy   <= 1'b0;
            state      <= ST_SINGLE;
          end else if (uart_fc && flush) begin
            single_req <= 1'b1;
            last       <= 1'b1;
            is_dummy   <= 1'b1;
            dummy_flag <= 1'b1;
            state      <= ST_SINGLE;
          end
        end
        ST_BURST: begin
          if (dma_ack) begin
            burst_req <= 1'b0;
            pop       <= 1'b1;
            pop_cnt   <= burst_len;
            state     <= ST_SETTLE;
          end
        end
        ST_SINGLE: begin
          if (dma_ack) begin
            single_req <= 1'b0;
            last       <= 1'b0;
            pop        <= !is_dummy;
            pop_cnt    <= is_dummy ? '0 : ONE_ENTRY;
            state      <= ST_SETTLE;
            if (last) begin
              flush    <= 1'b0;
              blk_done <= 1'b1;
            end
          end
        end
        ST_SETTLE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R4: the two request lines are never high together
  assert_one_req_R4: assert property (@(posedge clk) disable iff (rst)
    !(burst_req && single_req));

  // R4: a burst request waits for its acknowledge
  assert_burst_hold_R4: assert property (@(posedge clk) disable iff (rst)
    burst_req && !dma_ack |=> burst_req);

  // R4: a single request waits for its acknowledge
  assert_single_hold_R4: assert property (@(posedge clk) disable iff (rst)
    single_req && !dma_ack |=> single_req);

  // R4: a pop strobe only follows an acknowledge
  assert_pop_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    pop |-> $past(dma_ack));

  // R2: a burst is raised only with a full burst in the FIFO
  assert_burst_level_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_req) |-> ($past(fifo_level) >= $past(burst_len)));

  // R6: last is only driven with a single in UART flow-control mode
  assert_last_mode_R6: assert property (@(posedge clk) disable iff (rst)
    last |-> (single_req && uart_fc));

  // R9: the dummy flag rises together with a last transfer
  assert_dummy_with_last_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(dummy_flag) |-> last);

endmodule

// File: rtl/uart_rx_dma_ctrl.sv
module uart_rx_dma_ctrl #(
  parameter int LVL_W = 5,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_uart_fc,
  input  logic [LVL_W-1:0] cfg_burst_len,
  input  logic [TMO_W-1:0] cfg_idle_thres,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             rx_char_stb,
  input  logic             dma_ack,
  input  logic             dummy_clr,
  output logic             dma_burst_req,
  output logic             dma_single_req,
  output logic             dma_last,
  output logic             fifo_pop,
  output logic [LVL_W-1:0] fifo_pop_cnt,
  output logic             dummy_flag
);

  logic tmo;
  logic blk_done;

  rx_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .enable   (cfg_uart_fc),
    .char_stb (rx_char_stb),
    .clear    (blk_done),
    .thres    (cfg_idle_thres),
    .expire_o (tmo)
  );

  rx_dma_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .uart_fc    (cfg_uart_fc),
    .burst_len  (cfg_burst_len),
    .fifo_level (fifo_level),
    .dma_ack    (dma_ack),
    .tmo        (tmo),
    .dummy_clr  (dummy_clr),
    .burst_req  (dma_burst_req),
    .single_req (dma_single_req),
    .last       (dma_last),
    .pop        (fifo_pop),
    .pop_cnt    (fifo_pop_cnt),
    .dummy_flag (dummy_flag),
    .blk_done   (blk_done)
  );

endmodule

// File: tb/sim_uart_rx_dma_ctrl.sv
module sim_uart_rx_dma_ctrl;

  localparam int LVL_W = 5;
  localparam int TMO_W = 16;
  localparam int BURST = 4;
  localparam int THRES = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_uart_fc = 1'b0;
  logic [LVL_W-1:0] cfg_burst_len = LVL_W'(BURST);
  logic [TMO_W-1:0] cfg_idle_thres = TMO_W'(THRES);
  logic [LVL_W-1:0] fifo_level;
  logic             rx_char_stb = 1'b0;
  logic             dma_ack = 1'b0;
  logic             dummy_clr = 1'b0;
  logic             dma_burst_req, dma_single_req, dma_last, fifo_pop, dummy_flag;
  logic [LVL_W-1:0] fifo_pop_cnt;

  logic [LVL_W-1:0] lvl;
  logic [LVL_W-1:0] push_n = '0;
  int nchecks = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  uart_rx_dma_ctrl #(.LVL_W(LVL_W), .TMO_W(TMO_W)) u0 (
    .clk(clk), .rst(rst), .cfg_uart_fc(cfg_uart_fc), .cfg_burst_len(cfg_burst_len),
    .cfg_idle_thres(cfg_idle_thres), .fifo_level(fifo_level), .rx_char_stb(rx_char_stb),
    .dma_ack(dma_ack), .dummy_clr(dummy_clr), .dma_burst_req(dma_burst_req),
    .dma_single_req(dma_single_req), .dma_last(dma_last), .fifo_pop(fifo_pop),
    .fifo_pop_cnt(fifo_pop_cnt), .dummy_flag(dummy_flag)
  );

  // Bench FIFO model: pushes and pops applied at each edge
  always @(posedge clk) begin
    if (rst) lvl <= '0;
    else     lvl <= lvl + push_n - (fifo_pop ? fifo_pop_cnt : '0);
  end
  assign fifo_level = lvl;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, int act, int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req, int b, int s, int l);
    check(req, "burst_req", int'(dma_burst_req), b);
    check(req, "single_req", int'(dma_single_req), s);
    check(req, "last", int'(dma_last), l);
  endtask

  task automatic push(int n);
    rx_char_stb = 1'b1;
    push_n = LVL_W'(n);
    tick();
    rx_char_stb = 1'b0;
    push_n = '0;
  endtask

  task automatic do_ack();
    dma_ack = 1'b1;
    tick();
    dma_ack = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    check_outs("R1", 0, 0, 0);
    rst = 1'b0;
    tick();
    check_outs("R1", 0, 0, 0);
    check("R1", "pop", int'(fifo_pop), 0);
    check("R1", "dummy_flag", int'(dummy_flag), 0);
  endtask

  task automatic t_engine_burst();
    bit seen_last = 0;
    cfg_uart_fc = 1'b0;
    push(6);
    tick();
    check_outs("R2", 1, 0, 0);
    repeat (3) tick();
    check_outs("R4", 1, 0, 0);
    do_ack();
    check("R4", "pop", int'(fifo_pop), 1);
    check("R4", "pop_cnt burst", int'(fifo_pop_cnt), BURST);
    check("R4", "burst dropped", int'(dma_burst_req), 0);
    tick();
    check("R5", "settle single", int'(dma_single_req), 0);
    tick();
    check_outs("R3", 0, 1, 0);
    do_ack();
    check("R4", "pop_cnt single", int'(fifo_pop_cnt), 1);
    tick();
    tick();
    check("R5", "next single", int'(dma_single_req), 1);
    for (int i = 0; i < 30; i++) begin
      tick();
      if (dma_last) seen_last = 1;
    end
    check("R6", "last in engine mode", int'(seen_last), 0);
    check("R4", "single held", int'(dma_single_req), 1);
    do_ack();
    tick();
    tick();
    check_outs("R3", 0, 0, 0);
  endtask

  task automatic t_engine_single();
    cfg_uart_fc = 1'b0;
    push(3);
    tick();
    check_outs("R3", 0, 1, 0);
    for (int k = 0; k < 3; k++) begin
      do_ack();
      check("R4", "single pop", int'(fifo_pop), 1);
      tick();
      tick();
    end
    check_outs("R3", 0, 0, 0);
  endtask

  task automatic t_timeout_drain();
    bit seen_req = 0;
    cfg_uart_fc = 1'b1;
    push(6);
    tick();
    check_outs("R2", 1, 0, 0);
    do_ack();
    check("R4", "pop_cnt burst", int'(fifo_pop_cnt), BURST);
    repeat (THRES) tick();
    check("R8", "no single before timeout", int'(dma_single_req), 0);
    tick();
    check_outs("R7", 0, 1, 0);
    do_ack();
    check("R8", "drain pop", int'(fifo_pop), 1);
    tick();
    tick();
    check_outs("R8", 0, 1, 1);
    do_ack();
    check("R8", "last pop", int'(fifo_pop), 1);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (dma_single_req || dma_burst_req) seen_req = 1;
    end
    check("R11", "idle after last", int'(seen_req), 0);
    check("R11", "dummy_flag", int'(dummy_flag), 0);
  endtask

  task automatic t_restart();
    cfg_uart_fc = 1'b1;
    push(1);
    repeat (4) tick();
    push(1);
    repeat (THRES + 2) tick();
    check("R7", "restarted count", int'(dma_single_req), 0);
    tick();
    check_outs("R7", 0, 1, 0);
    do_ack();
    tick();
    tick();
    check_outs("R8", 0, 1, 1);
    do_ack();
    tick();
    tick();
  endtask

  task automatic t_dummy();
    bit seen_req = 0;
    cfg_uart_fc = 1'b1;
    push(BURST);
    tick();
    check_outs("R2", 1, 0, 0);
    do_ack();
    repeat (THRES) tick();
    check("R9", "no dummy early", int'(dummy_flag), 0);
    tick();
    check_outs("R9", 0, 1, 1);
    check("R9", "dummy_flag set", int'(dummy_flag), 1);
    do_ack();
    check("R9", "dummy pop", int'(fifo_pop), 0);
    check("R9", "single dropped", int'(dma_single_req), 0);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (dma_single_req || dma_burst_req) seen_req = 1;
    end
    check("R11", "idle after dummy", int'(seen_req), 0);
    check("R10", "flag sticky", int'(dummy_flag), 1);
    dummy_clr = 1'b1;
    tick();
    dummy_clr = 1'b0;
    check("R10", "flag cleared", int'(dummy_flag), 0);
  endtask

  initial begin
    t_reset();
    t_engine_burst();
    t_engine_single();
    t_timeout_drain();
    t_restart();
    t_dummy();
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

endmodule